// File: doc/BRIEF.md
# Single-Wire Manchester Bus Master

This block is the controlling end of a one-wire serial bus. Clock and data share one open-drain line, with each bit Manchester-coded. The block takes one request at a time. It opens each transaction in one of two ways: with a long standby pulse (the line driven high), or with only a short setup gap (the line released). It then drives the header low time and the synchronisation byte. Next it sends the device address byte, the command, an optional 16-bit word address, and either write data or slave-returned read data. After every byte it runs the two-slot acknowledge exchange.

All timing comes from configuration inputs given in clock cycles: half the bit period, the header low time, the standby pulse length and the setup gap. The master decides its own acknowledge bit. It sends "continue" after every byte except the final one, which gets "stop". It samples the slave's acknowledge slot on both sides of the expected mid-bit edge. A missing slave acknowledge aborts the transaction with a standby pulse and an error flag.

Top module: `sw_bus_master`

## Requirements
- R1: Before each header the line is high for a lead-in time. If the previous transaction ended with a final "stop" acknowledge answered by the slave, and `req_dev` equals that transaction's device code, the master releases the line (`bus_oe`=0) for `cfg_gap` cycles. Otherwise it drives a standby pulse (`bus_oe`=1, `bus_o`=1) for `cfg_stby` cycles. After reset the standby pulse is always used. The lead-in starts in the cycle after the request is accepted.
- R2: The header drives the line low for exactly `cfg_hdr` cycles. The first bit of the byte 0x55 begins in the next cycle.
- R3: Every bit lasts 2*`cfg_half` cycles. A 1 is low in the first half and high in the second half; a 0 is the reverse. Bytes go out MSB first.
- R4: Byte order is as follows. First 0x55. Then the address byte, whose upper nibble is 1010 and whose lower nibble is `req_dev`. Then `req_cmd`. When `req_addr_en`=1, `req_addr[15:8]` and then `req_addr[7:0]` follow. The last part is `req_len` data bytes.
- R5: After each byte the master sends its acknowledge bit. The value is 1 after every byte except the last byte of the transaction, which gets 0.
- R6: During the slave acknowledge slot the master releases the line. It accepts the acknowledge only if the line is low at cycle `cfg_half`/2 of the slot and high at cycle `cfg_half`+`cfg_half`/2. The result of the slot after 0x55 is ignored.
- R7: A missing acknowledge after any byte other than 0x55 ends the transaction. The master drives a standby pulse for `cfg_stby` cycles, then pulses `done` with `err`=1. The next transaction then opens with a standby pulse.
- R8: When `req_read`=1, the master releases the line for the data bytes. It takes each bit as the level in the second half of the bit. Each byte appears on `rd_data` with a one-cycle `rd_valid` in the first cycle of the master's acknowledge bit.
- R9: When `req_read`=0, each data byte is loaded from `wr_data`. A one-cycle `wr_take` in the first cycle of that byte's first bit tells the source to present the next byte.
- R10: `req_ready` is high only when idle, and `req_valid` is ignored while busy. After a successful final acknowledge slot, `done` pulses for one cycle in the next cycle with `err`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_half | input | TW | Half bit period in cycles |
| cfg_hdr | input | TW | Header low time in cycles |
| cfg_stby | input | TW | Standby pulse length in cycles |
| cfg_gap | input | TW | Setup gap in cycles |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Idle, request accepted this cycle |
| req_dev | input | 4 | Device code (address low nibble) |
| req_cmd | input | 8 | Command byte |
| req_addr_en | input | 1 | Send two word-address bytes |
| req_addr | input | 16 | Word address |
| req_len | input | LW | Number of data bytes |
| req_read | input | 1 | Data bytes come from the slave |
| wr_data | input | 8 | Next write byte |
| wr_take | output | 1 | Write byte consumed |
| rd_data | output | 8 | Received byte |
| rd_valid | output | 1 | `rd_data` valid |
| done | output | 1 | Transaction finished |
| err | output | 1 | Finished transaction failed |
| line_i | input | 1 | Sensed bus level |
| bus_oe | output | 1 | Master drives the line |
| bus_o | output | 1 | Level driven when `bus_oe`=1 |

## Verification
The lead-in starts in the first cycle after acceptance. The header low begins after exactly the lead-in length, and bit zero starts on the rising edge that ends the header. From that edge on, the bench counts falling edges: every result sits at a fixed cycle offset inside a 2*`cfg_half` bit grid. Line levels are read at the quarter and three-quarter points of each bit. `wr_take` is checked at offset zero of a write byte. `rd_valid` is checked at offset zero of the acknowledge bit that follows a read byte. `done` is checked one cycle after the final slot, or after exactly `cfg_stby` high cycles on the error path.

// File: rtl/swm_pkg.sv
package swm_pkg;
    typedef enum logic [2:0] {
        S_IDLE, S_PRE, S_HLOW, S_BYTE, S_MACK, S_SACK, S_ESTB
    } swm_state_e;

    typedef enum logic [2:0] {
        K_SYNC, K_DEV, K_CMD, K_AHI, K_ALO, K_DATA
    } swm_kind_e;

    localparam logic [7:0] SWM_SYNC_BYTE = 8'h55;
    localparam logic [3:0] SWM_FAMILY    = 4'hA;
endpackage

// File: rtl/swm_bit_clock.sv
module swm_bit_clock #(
    parameter int TW = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic [TW-1:0] half,
    output logic [TW-1:0] cnt,
    output logic          bit_end,
    output logic          early,
    output logic          late,
    output logic          second
);
    logic [TW-1:0] cnt_d, cnt_q;
    logic [TW-1:0] full_w, quarter_w;

    always_comb begin
        cnt_d = restart ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign full_w    = half << 1;
    assign quarter_w = half >> 1;
    assign cnt       = cnt_q;
    assign bit_end   = (cnt_q == full_w - 1'b1);
    assign early     = (cnt_q == quarter_w);
    assign late      = (cnt_q == half + quarter_w);
    assign second    = (cnt_q >= half);
endmodule

// File: rtl/swm_shift.sv
module swm_shift (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [7:0] load_val,
    input  logic       shift,
    input  logic       in_bit,
    output logic [7:0] val
);
    logic [7:0] val_d, val_q;

    always_comb begin
        if (load)       val_d = load_val;
        else if (shift) val_d = {val_q[6:0], in_bit};
        else            val_d = val_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) val_q <= '0;
        else        val_q <= val_d;
    end

    assign val = val_q;
endmodule

// File: rtl/swm_seq.sv
module swm_seq
    import swm_pkg::*;
#(
    parameter int LW = 8
) (
    input  swm_kind_e         kind,
    input  logic              addr_en,
    input  logic [LW-1:0]     left,
    output logic              is_last,
    output swm_kind_e         nxt
);
    always_comb begin
        is_last = ((kind == K_DATA) && (left == LW'(1))) ||
                  ((left == '0) && (((kind == K_CMD) && !addr_en) || (kind == K_ALO)));
        unique case (kind)
            K_SYNC:  nxt = K_DEV;
            K_DEV:   nxt = K_CMD;
            K_CMD:   nxt = addr_en ? K_AHI : K_DATA;
            K_AHI:   nxt = K_ALO;
            default: nxt = K_DATA;
        endcase
    end
endmodule

// File: rtl/sw_bus_master.sv
module sw_bus_master
    import swm_pkg::*;
#(
    parameter int TW = 20,
    parameter int LW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] cfg_half,
    input  logic [TW-1:0] cfg_hdr,
    input  logic [TW-1:0] cfg_stby,
    input  logic [TW-1:0] cfg_gap,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [3:0]    req_dev,
    input  logic [7:0]    req_cmd,
    input  logic          req_addr_en,
    input  logic [15:0]   req_addr,
    input  logic [LW-1:0] req_len,
    input  logic          req_read,
    input  logic [7:0]    wr_data,
    output logic          wr_take,
    output logic [7:0]    rd_data,
    output logic          rd_valid,
    output logic          done,
    output logic          err,
    input  logic          line_i,
    output logic          bus_oe,
    output logic          bus_o
);
    typedef struct packed {
        swm_state_e    state;
        swm_kind_e     kind;
        logic [2:0]    bitn;
        logic [LW-1:0] left;
        logic [3:0]    dev;
        logic [7:0]    cmd;
        logic          aen;
        logic [15:0]   addr;
        logic          rd;
        logic          stby;
        logic          clean;
        logic [3:0]    last_dev;
        logic          sak_lo;
        logic          sak_hi;
        logic          done;
        logic          err;
        logic          take;
        logic          rdv;
        logic [7:0]    rdat;
    } swm_regs_t;

    swm_regs_t q, n;

    logic          restart, bit_end, early, late, second;
    logic [TW-1:0] cnt, pre_len;
    logic          ld, sh_en, is_last, rx_byte, mak, oe_c, o_c;
    logic [7:0]    ld_val, sh;
    swm_kind_e     nxt;

    swm_bit_clock #(.TW(TW)) i_clk_cnt (
        .clk(clk), .rst_n(rst_n), .restart(restart), .half(cfg_half),
        .cnt(cnt), .bit_end(bit_end), .early(early), .late(late), .second(second)
    );

    swm_shift i_shift (
        .clk(clk), .rst_n(rst_n), .load(ld), .load_val(ld_val),
        .shift(sh_en), .in_bit(line_i), .val(sh)
    );

    swm_seq #(.LW(LW)) i_seq (
        .kind(q.kind), .addr_en(q.aen), .left(q.left),
        .is_last(is_last), .nxt(nxt)
    );

    assign pre_len = q.stby ? cfg_stby : cfg_gap;
    assign rx_byte = (q.kind == K_DATA) && q.rd;
    assign mak     = !is_last;

    always_comb begin
        n        = q;
        n.done   = 1'b0;
        n.take   = 1'b0;
        n.rdv    = 1'b0;
        restart  = 1'b0;
        ld       = 1'b0;
        ld_val   = 8'h00;
        sh_en    = 1'b0;
        oe_c     = 1'b0;
        o_c      = 1'b1;
        unique case (q.state)
            S_IDLE: begin
                restart = 1'b1;
                if (req_valid) begin
                    n.state = S_PRE;
                    n.kind  = K_SYNC;
                    n.dev   = req_dev;
                    n.cmd   = req_cmd;
                    n.aen   = req_addr_en;
                    n.addr  = req_addr;
                    n.rd    = req_read;
                    n.left  = req_len;
                    n.stby  = !(q.clean && (req_dev == q.last_dev));
                    n.clean = 1'b0;
                end
            end
            S_PRE: begin
                oe_c = q.stby;
                if (cnt == pre_len - 1'b1) begin
                    restart = 1'b1;
                    n.state = S_HLOW;
                end
            end
            S_HLOW: begin
                oe_c = 1'b1;
                o_c  = 1'b0;
                if (cnt == cfg_hdr - 1'b1) begin
                    restart = 1'b1;
                    n.state = S_BYTE;
                    n.bitn  = 3'd0;
                    ld      = 1'b1;
                    ld_val  = SWM_SYNC_BYTE;
                end
            end
            S_BYTE: begin
                if (!rx_byte) begin
                    oe_c = 1'b1;
                    o_c  = second ? sh[7] : ~sh[7];
                end
                if (rx_byte && late) sh_en = 1'b1;
                if (bit_end) begin
                    restart = 1'b1;
                    if (!rx_byte) sh_en = 1'b1;
                    n.bitn = q.bitn + 3'd1;
                    if (q.bitn == 3'd7) begin
                        n.state = S_MACK;
                        if (rx_byte) begin
                            n.rdv  = 1'b1;
                            n.rdat = sh;
                        end
                    end
                end
            end
            S_MACK: begin
                oe_c = 1'b1;
                o_c  = second ? mak : ~mak;
                if (bit_end) begin
                    restart  = 1'b1;
                    n.state  = S_SACK;
                    n.sak_lo = 1'b0;
                    n.sak_hi = 1'b0;
                end
            end
            S_SACK: begin
                if (early) n.sak_lo = !line_i;
                if (late)  n.sak_hi = line_i;
                if (bit_end) begin
                    restart = 1'b1;
                    if ((q.kind != K_SYNC) && !(q.sak_lo && q.sak_hi)) begin
                        n.state = S_ESTB;
                    end else if (is_last) begin
                        n.state    = S_IDLE;
                        n.done     = 1'b1;
                        n.err      = 1'b0;
                        n.clean    = 1'b1;
                        n.last_dev = q.dev;
                    end else begin
                        n.state = S_BYTE;
                        n.bitn  = 3'd0;
                        n.kind  = nxt;
                        if (q.kind == K_DATA) n.left = q.left - 1'b1;
                        ld = 1'b1;
                        unique case (nxt)
                            K_DEV:   ld_val = {SWM_FAMILY, q.dev};
                            K_CMD:   ld_val = q.cmd;
                            K_AHI:   ld_val = q.addr[15:8];
                            K_ALO:   ld_val = q.addr[7:0];
                            default: begin
                                if (!q.rd) begin
                                    ld_val = wr_data;
                                    n.take = 1'b1;
                                end
                            end
                        endcase
                    end
                end
            end
            S_ESTB: begin
                oe_c = 1'b1;
                if (cnt == cfg_stby - 1'b1) begin
                    n.state = S_IDLE;
                    n.done  = 1'b1;
                    n.err   = 1'b1;
                end
            end
            default: n.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= S_IDLE;
            q.kind  <= K_SYNC;
        end else begin
            q <= n;
        end
    end

    assign req_ready = (q.state == S_IDLE);
    assign done      = q.done;
    assign err       = q.err;
    assign wr_take   = q.take;
    assign rd_valid  = q.rdv;
    assign rd_data   = q.rdat;
    assign bus_oe    = oe_c;
    assign bus_o     = o_c;
endmodule

// File: rtl/swm_checker.sv
module swm_checker (
    input logic clk,
    input logic rst_n,
    input logic req_ready,
    input logic done,
    input logic err,
    input logic wr_take,
    input logic rd_valid,
    input logic bus_o
);
    // R10: completion only reported while idle
    a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> req_ready);
    // R10: done is a single-cycle pulse
    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R9: one take pulse per byte
    a_r9_take_single: assert property (@(posedge clk) disable iff (!rst_n)
        wr_take |=> !wr_take);
    // R8: one valid pulse per byte
    a_r8_rdv_single: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);
    // R1: lead-in starts with the line high
    a_r1_lead_high: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(req_ready) |-> bus_o);
    // R7: error flag only changes with a completion
    a_r7_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        (err != $past(err)) |-> done);
endmodule

bind sw_bus_master swm_checker i_swm_checker (
    .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .done(done),
    .err(err), .wr_take(wr_take), .rd_valid(rd_valid), .bus_o(bus_o)
);

// File: tb/test_sw_bus_master.sv
module test_sw_bus_master;
    localparam int TW = 20;
    localparam int LW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [TW-1:0] cfg_half, cfg_hdr, cfg_stby, cfg_gap;
    logic          req_valid, req_ready, req_addr_en, req_read;
    logic [3:0]    req_dev;
    logic [7:0]    req_cmd, wr_data, rd_data;
    logic [15:0]   req_addr;
    logic [LW-1:0] req_len;
    logic          wr_take, rd_valid, done, err, bus_oe, bus_o;
    logic          s_oe, s_o;
    wire           line;
    int            total = 0, bad = 0, widx = 0, ridx = 0;

    always #4 clk = ~clk;

    assign line = bus_oe ? bus_o : (s_oe ? s_o : 1'b1);

    function automatic logic [7:0] wpat(input int i);
        return 8'(8'h3C + i * 17);
    endfunction
    function automatic logic [7:0] rpat(input int i);
        return 8'(8'hC3 ^ (i * 29));
    endfunction

    assign wr_data = wpat(widx);

    sw_bus_master #(.TW(TW), .LW(LW)) i_sw_bus_master (
        .clk(clk), .rst_n(rst_n), .cfg_half(cfg_half), .cfg_hdr(cfg_hdr),
        .cfg_stby(cfg_stby), .cfg_gap(cfg_gap), .req_valid(req_valid),
        .req_ready(req_ready), .req_dev(req_dev), .req_cmd(req_cmd),
        .req_addr_en(req_addr_en), .req_addr(req_addr), .req_len(req_len),
        .req_read(req_read), .wr_data(wr_data), .wr_take(wr_take),
        .rd_data(rd_data), .rd_valid(rd_valid), .done(done), .err(err),
        .line_i(line), .bus_oe(bus_oe), .bus_o(bus_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    initial forever begin
        @(negedge clk);
        if (wr_take) widx++;
        if (rd_valid) begin
            chk("R8 read byte value", int'(rd_data), int'(rpat(ridx)));
            ridx++;
        end
    end

    task automatic txn(input logic [3:0] dev, input logic [7:0] cmd, input bit aen,
                       input logic [15:0] addr, input int n, input bit rd,
                       input bit exp_stby, input int nosak_at, input bit poke);
        int nb, fd, hp, pre, lo, c;
        bit oe_ok, man_ok, drv, e1, e2, mrx, give;
        logic [7:0] exp_b, got;
        nb = (aen ? 5 : 3) + n;
        fd = nb - n;
        hp = int'(cfg_half);
        e1 = 1'b0; e2 = 1'b0;
        @(negedge clk);
        widx = 0; ridx = 0;
        chk("R10 ready while idle", int'(req_ready), 1);
        req_dev = dev; req_cmd = cmd; req_addr_en = aen; req_addr = addr;
        req_len = LW'(n); req_read = rd; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        pre = 0; oe_ok = 1'b1;
        while (line == 1'b1 && pre < 100000) begin
            if (bus_oe != exp_stby) oe_ok = 1'b0;
            pre++;
            @(negedge clk);
        end
        if (exp_stby) chk("R1 standby pulse length", pre, int'(cfg_stby));
        else          chk("R1 setup gap length", pre, int'(cfg_gap));
        chk("R1 lead-in drive mode", int'(oe_ok), 1);
        lo = 0;
        while (line == 1'b0 && lo < 100000) begin
            lo++;
            @(negedge clk);
        end
        chk("R2 header low time", lo, int'(cfg_hdr));
        for (int k = 0; k < nb; k++) begin
            mrx = rd && (k >= fd);
            if (k == 0)      exp_b = 8'h55;
            else if (k == 1) exp_b = {4'b1010, dev};
            else if (k == 2) exp_b = cmd;
            else if (k < fd) exp_b = (k == 3) ? addr[15:8] : addr[7:0];
            else             exp_b = mrx ? rpat(k - fd) : wpat(k - fd);
            man_ok = 1'b1; drv = 1'b0; got = 8'h00;
            for (int b = 0; b < 8; b++) begin
                for (int j = 0; j < 2 * hp; j++) begin
                    if (j == 0) begin s_oe = mrx; s_o = ~exp_b[7-b]; end
                    if (j == hp) s_o = exp_b[7-b];
                    if (mrx && bus_oe) drv = 1'b1;
                    if (b == 0 && j == 0 && !rd && k >= fd)
                        chk("R9 wr_take at first bit of data byte", int'(wr_take), 1);
                    if (poke && k == 1 && b == 0 && j == 0) begin
                        req_valid = 1'b1; req_dev = ~dev; req_cmd = ~cmd;
                    end
                    if (poke && k == 1 && b == 0 && j == 1) req_valid = 1'b0;
                    if (j == hp / 2) e1 = line;
                    if (j == hp + hp / 2) begin
                        e2 = line; got[7-b] = e2;
                        if (e1 == e2) man_ok = 1'b0;
                    end
                    @(negedge clk);
                end
            end
            if (mrx) chk("R8 line released in read byte", int'(drv), 0);
            else begin
                chk("R4 byte value in order (R10 busy request ignored)", int'(got), int'(exp_b));
                chk("R3 manchester halves", int'(man_ok), 1);
            end
            for (int j = 0; j < 2 * hp; j++) begin
                if (j == 0) begin
                    s_oe = 1'b0;
                    if (mrx) chk("R8 rd_valid at ack start", int'(rd_valid), 1);
                end
                if (j == hp / 2) e1 = line;
                if (j == hp + hp / 2) e2 = line;
                @(negedge clk);
            end
            chk("R5 master acknowledge value", int'(e2), (k == nb - 1) ? 0 : 1);
            chk("R3 acknowledge halves", int'(e1 != e2), 1);
            give = (k != 0) && (k != nosak_at);
            drv = 1'b0;
            for (int j = 0; j < 2 * hp; j++) begin
                if (j == 0) begin s_oe = give; s_o = 1'b0; end
                if (j == hp) s_o = 1'b1;
                if (bus_oe) drv = 1'b1;
                @(negedge clk);
            end
            s_oe = 1'b0;
            chk("R6 released in slave ack slot", int'(drv), 0);
            if (k == nosak_at) break;
        end
        if (nosak_at >= 0) begin
            c = 0;
            while (!done && c < 100000) begin
                if (bus_oe && line) c++;
                @(negedge clk);
            end
            chk("R7 error standby length", c, int'(cfg_stby));
            chk("R7 error flag", int'(err), 1);
        end else begin
            chk("R10 done after final ack", int'(done), 1);
            chk("R10 error flag clear", int'(err), 0);
            if (rd) chk("R8 read bytes delivered", ridx, n);
            else    chk("R9 write bytes taken", widx, n);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        cfg_half = 4; cfg_hdr = 10; cfg_stby = 40; cfg_gap = 12;
        req_valid = 0; req_dev = 0; req_cmd = 0; req_addr_en = 0;
        req_addr = 0; req_len = 0; req_read = 0; s_oe = 0; s_o = 1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 reset ready", int'(req_ready), 1);
        chk("R10 reset done", int'(done), 0);
        chk("R6 reset line released", int'(bus_oe), 0);
        chk("R9 reset take", int'(wr_take), 0);
        // first after reset: standby, command only, stop after command
        txn(4'h0, 8'h96, 1'b0, 16'h0000, 0, 1'b0, 1'b1, -1, 1'b0);
        // same device: short gap, addressed write, busy request poked
        txn(4'h0, 8'h6C, 1'b1, 16'h0130, 3, 1'b0, 1'b0, -1, 1'b1);
        // same device: addressed read
        txn(4'h0, 8'h03, 1'b1, 16'h07F0, 4, 1'b1, 1'b0, -1, 1'b0);
        // other device: standby again
        txn(4'h1, 8'h06, 1'b0, 16'h0000, 2, 1'b1, 1'b1, -1, 1'b0);
        // slower bit period
        cfg_half = 6;
        txn(4'h1, 8'h05, 1'b0, 16'h0000, 1, 1'b1, 1'b0, -1, 1'b0);
        // missing ack after the command
        txn(4'h1, 8'h6C, 1'b1, 16'h0000, 2, 1'b0, 1'b0, 2, 1'b0);
        // after an error the standby pulse returns even for the same device
        txn(4'h1, 8'h05, 1'b0, 16'h0000, 1, 1'b1, 1'b1, -1, 1'b0);
        cfg_half = 4;
        // missing ack after the final data byte
        txn(4'h1, 8'h6C, 1'b1, 16'h00AB, 1, 1'b0, 1'b0, 5, 1'b0);
        txn(4'h0, 8'h91, 1'b0, 16'h0000, 0, 1'b0, 1'b1, -1, 1'b0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule